// File: doc/BRIEF.md
# Multi-Channel Output Compare Unit

This block is a timer peripheral built around one shared free-running 16-bit counter and eight compare channels. Each channel holds a 16-bit compare value. When the counter reaches that value, the channel raises its event flag and applies a 2-bit action to its output pin. The action can leave the pin alone, toggle it, drive it low or drive it high. A per-channel mask decides whether a raised flag contributes to the interrupt request.

A CPU programs the block through a write-only register port. Through it, software loads compare values, picks which channels act as compares, sets the action codes and the interrupt masks, starts and stops the counter, and clears flags by writing ones. Because a flag is cleared by writing one, software can service a match and then place the next edge at the old compare value plus a delay, which produces waveforms with precise timing.

The counter value, the flags, the interrupt request and the pins are visible on output ports. When a pin is not under compare control, it shows a separately written general-purpose value.

Top module: `oc_unit`

## Requirements
- R1: A channel acts as a compare only when its bit in the select register (address 9, bit n = channel n) is 1. An unselected channel never raises its flag, and its pin shows the general-purpose value.
- R2: A match is declared in a cycle where the counter advanced on the previous clock and the counter equals the channel's compare value. The channel's flag reads 1 from the next clock on.
- R3: The action field for channel n sits in bits 2n+1:2n of the action register (address 10). The codes are 00 = disconnected (pin register unchanged, pin shows the general-purpose value), 01 = toggle, 10 = drive low and 11 = drive high, each applied on a match.
- R4: Writing data to the flag-clear address (11) clears every flag whose data bit is 1 and leaves the others unchanged. A match in the same cycle as the clear wins, and the flag stays set.
- R5: `irq_o` is 1 exactly when some channel has both its flag and its mask bit (address 12, bit n) set.
- R6: The counter advances by one per clock, wrapping from 0xFFFF to 0, only while bit 0 of the control register (address 8) is 1. Otherwise it holds.
- R7: After reset the counter, flags, pin registers, masks, select bits, action codes, general-purpose values (address 13) and the enable bit are all 0.
- R8: A compare value held constant yields exactly one match per counter wrap. A stopped counter yields no further matches.
- R9: A compare value written at addresses 0..7 (channel = address) takes effect on the next clock. A value equal to the count at the time of the write does not fire until the counter comes back to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register write address |
| wdata_i | input | 16 | Register write data |
| count_o | output | 16 | Current counter value |
| flag_o | output | 8 | Per-channel match flags |
| irq_o | output | 1 | Interrupt request |
| pin_o | output | 8 | Channel output pins |

## Verification
On every cycle the embedded assertions check how the counter steps or holds, that a match sets its flag on the next clock, the effect of each action code on the pin register, that a pin register holds when there is no match, and that a flag-clear write takes effect. Other behaviours depend on a sequence of register writes, so only the bench scenarios can show them. These are the one-event-per-wrap property, the rule that a compare value equal to the count at the time of the write must not fire, a clear that lands in the same cycle as a match, and interrupt masking. A behavioural model in the bench tracks count, flags, pins and interrupt on every clock.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [1:0] {
    ACT_OFF = 2'b00,
    ACT_TOG = 2'b01,
    ACT_CLR = 2'b10,
    ACT_SET = 2'b11
  } oc_act_e;
endpackage

// File: rtl/oc_counter.sv
module oc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             adv_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             adv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      adv_q <= 1'b0;
    end else begin
      adv_q <= en_i;
      if (en_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign adv_o = adv_q;

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
  a_r6_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  oc_act_e          act_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             adv_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             clr_i,
  input  logic             gpio_i,
  output logic             flag_o,
  output logic             pin_o
);
  logic [CNT_W-1:0] cmp_q;
  logic             flag_q;
  logic             pin_q;
  logic             hit;

  assign hit = sel_i && adv_i && (cnt_i == cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmp_q <= '0;
    else if (cmp_we_i) cmp_q <= cmp_i;
  end

  // set has priority over a write-one clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else if (hit) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else if (hit) begin
      unique case (act_i)
        ACT_TOG: pin_q <= ~pin_q;
        ACT_CLR: pin_q <= 1'b0;
        ACT_SET: pin_q <= 1'b1;
        default: pin_q <= pin_q;
      endcase
    end
  end

  assign flag_o = flag_q;
  assign pin_o  = (sel_i && act_i != ACT_OFF) ? pin_q : gpio_i;

  a_r2_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> flag_q);
  a_r4_flag_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit) |=> !flag_q);
  a_r3_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && act_i == ACT_SET) |=> pin_q);
  a_r3_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && act_i == ACT_CLR) |=> !pin_q);
  a_r3_tog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && act_i == ACT_TOG) |=> pin_q != $past(pin_q));
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit || act_i == ACT_OFF) |=> $stable(pin_q));
endmodule

// File: rtl/oc_unit.sv
module oc_unit
  import oc_pkg::*;
#(
  parameter int N_CH   = 8,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [N_CH-1:0]   flag_o,
  output logic              irq_o,
  output logic [N_CH-1:0]   pin_o
);
  localparam int ACT_W = 2 * N_CH;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(N_CH);
  localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(N_CH + 1);
  localparam logic [ADDR_W-1:0] A_ACT  = ADDR_W'(N_CH + 2);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(N_CH + 3);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(N_CH + 4);
  localparam logic [ADDR_W-1:0] A_GPIO = ADDR_W'(N_CH + 5);

  logic             en_q;
  logic [N_CH-1:0]  sel_q, mask_q, gpio_q, clr;
  logic [ACT_W-1:0] act_q;
  logic [CNT_W-1:0] cnt;
  logic             adv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      sel_q  <= '0;
      act_q  <= '0;
      mask_q <= '0;
      gpio_q <= '0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        A_CTRL:  en_q   <= wdata_i[0];
        A_SEL:   sel_q  <= wdata_i[N_CH-1:0];
        A_ACT:   act_q  <= wdata_i[ACT_W-1:0];
        A_MASK:  mask_q <= wdata_i[N_CH-1:0];
        A_GPIO:  gpio_q <= wdata_i[N_CH-1:0];
        default: ;
      endcase
    end
  end

  assign clr = (wr_en_i && addr_i == A_CLR) ? wdata_i[N_CH-1:0] : '0;

  oc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_q),
    .cnt_o (cnt),
    .adv_o (adv)
  );

  for (genvar n = 0; n < N_CH; n++) begin : g_ch
    oc_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sel_i   (sel_q[n]),
      .act_i   (oc_act_e'(act_q[2*n +: 2])),
      .cnt_i   (cnt),
      .adv_i   (adv),
      .cmp_we_i(wr_en_i && addr_i == ADDR_W'(n)),
      .cmp_i   (wdata_i),
      .clr_i   (clr[n]),
      .gpio_i  (gpio_q[n]),
      .flag_o  (flag_o[n]),
      .pin_o   (pin_o[n])
    );
  end

  assign count_o = cnt;
  assign irq_o   = |(flag_o & mask_q);

  a_r1_unsel_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_q[0] && !flag_o[0] && clr[0] == 1'b0) |=> !flag_o[0]);
endmodule

// File: tb/oc_unit_bench.sv
module oc_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] count;
  logic [7:0]  flag, pin;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // behavioural model
  int m_cnt, m_adv, m_en, m_sel, m_mask, m_gpio, m_act, m_flag, m_pin;
  int m_cmp[8];

  always #10 clk = ~clk;

  oc_unit u_oc_unit (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .count_o(count), .flag_o(flag), .irq_o(irq), .pin_o(pin)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_adv = 0; m_en = 0; m_sel = 0; m_mask = 0; m_gpio = 0;
      m_act = 0; m_flag = 0; m_pin = 0;
      foreach (m_cmp[i]) m_cmp[i] = 0;
    end else begin
      int clr;
      int nflag, npin;
      clr = (wr_en && addr == 11) ? wdata[7:0] : 0;
      nflag = m_flag; npin = m_pin;
      for (int n = 0; n < 8; n++) begin
        int a;
        a = (m_act >> (2*n)) & 3;
        if (m_adv != 0 && ((m_sel >> n) & 1) != 0 && m_cnt == m_cmp[n]) begin
          nflag |= (1 << n);
          if (a == 1) npin ^= (1 << n);
          if (a == 2) npin &= ~(1 << n);
          if (a == 3) npin |= (1 << n);
        end else if (((clr >> n) & 1) != 0) nflag &= ~(1 << n);
      end
      m_flag = nflag; m_pin = npin;
      m_adv = m_en;
      if (m_en != 0) m_cnt = (m_cnt + 1) & 16'hFFFF;
      if (wr_en) begin
        if (addr < 8) m_cmp[addr] = wdata;
        case (addr)
          8:  m_en = wdata[0];
          9:  m_sel = wdata[7:0];
          10: m_act = wdata;
          12: m_mask = wdata[7:0];
          13: m_gpio = wdata[7:0];
          default: ;
        endcase
      end
    end
  end

  function automatic int exp_pin();
    int p;
    p = 0;
    for (int n = 0; n < 8; n++) begin
      bit drv;
      drv = ((m_sel >> n) & 1) != 0 && ((m_act >> (2*n)) & 3) != 0;
      if (drv ? ((m_pin >> n) & 1) : ((m_gpio >> n) & 1)) p |= (1 << n);
    end
    return p;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 count", count, m_cnt);
      chk("R2/R4 flag", flag, m_flag);
      chk("R3/R1 pin", pin, exp_pin());
      chk("R5 irq", irq, (m_flag & m_mask) != 0);
    end
  end

  task automatic wr(int a, int d);
    wr_en = 1'b1; addr = 4'(a); wdata = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset count", count, 0);
    chk("R7 reset flags", flag, 0);
    chk("R7 reset pins", pin, 0);
    chk("R7 reset irq", irq, 0);
    repeat (3) @(negedge clk);
    chk("R6 held when disabled", count, 0);

    // R1: unselected channel with matching compare and toggle
    wr(13, 8'h80);            // gpio ch7 = 1
    wr(1, 5);                 // cmp1 = 5
    wr(10, 16'h0004);         // ch1 toggle
    wr(8, 1);
    repeat (12) @(negedge clk);
    chk("R1 unselected no flag", flag[1], 0);
    chk("R1 unselected pin is gpio", pin, 8'h80);

    // R3: each action code, channels 0..3 = off,toggle,clear,set
    wr(8, 0);
    wr(13, 8'h01);
    for (int n = 0; n < 4; n++) wr(n, count + 8);
    wr(10, 16'b11_10_01_00);
    wr(9, 8'h0F);
    wr(12, 8'h02);
    wr(8, 1);
    repeat (12) @(negedge clk);
    chk("R3 action pins", pin[3:0], 4'b1011);
    chk("R2 flags selected", flag[3:0], 4'hF);
    chk("R5 irq masked ch1", irq, 1);

    // R4: write-one clear of ch1, ch2 only
    wr(11, 8'h06);
    chk("R4 clear selected bits", flag[3:0], 4'b1001);
    wr(12, 8'h06);
    chk("R5 irq gated by mask", irq, 0);

    // R4: clear in the same cycle as a match
    wr(11, 8'hFF);
    wr(0, count + 3);
    while (count != m_cmp[0]) @(negedge clk);
    wr(11, 8'h01);
    chk("R4 set wins over clear", flag[0], 1);

    // R9: compare equal to current count does not fire
    wr(11, 8'hFF);
    wr(2, count);
    repeat (20) @(negedge clk);
    chk("R9 equal value no fire", flag[2], 0);
    wr(2, count + 2);
    repeat (3) @(negedge clk);
    chk("R9 new value takes effect", flag[2], 1);

    // R8: stopped counter gives no repeats
    wr(8, 0);
    wr(11, 8'hFF);
    wr(3, count);
    repeat (10) @(negedge clk);
    chk("R8 stopped counter no match", flag[3], 0);

    // R8: exactly one toggle per wrap
    wr(9, 8'h20);
    wr(10, 16'h0400);
    wr(5, 16'h1234);
    wr(8, 1);
    begin
      int tog;
      logic prev;
      tog = 0; prev = pin[5];
      for (int i = 0; i < 65536; i++) begin
        @(negedge clk);
        if (pin[5] != prev) tog++;
        prev = pin[5];
      end
      chk("R8 one event per wrap", tog, 1);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule